// File: doc/BRIEF.md
# Byte-Packing Clock-Crossing FIFO With Latency-Aware Backpressure

This block accepts a stream of bytes in a 20 MHz producer clock domain and groups every four bytes into one 32-bit word. Each finished word goes into a 1024-word store that is read in an independent 33 MHz consumer domain. The read port is fall-through: the oldest word sits on `rd_data` whenever `rd_empty` is low, and `rd_en` removes it. Read and write pointers cross between the domains in Gray code through two-stage synchronizers.

The upstream sender is throttled through `hold_off`. The sender reacts to it only at the end of a fixed-size transfer cell, so after it rises up to `LAT_WORDS` more words can still arrive. A plain level threshold would ignore that latency. Instead, once occupancy has reached three quarters of the depth, the block counts the words written from that point on. It raises `hold_off` when the count shows that exactly `LAT_WORDS` free entries are left. It lowers `hold_off` only after occupancy, as seen from the write side, has fallen below three quarters. If a word is ever completed while the store is full, that word is dropped and a sticky `overflow` flag is set. A sender that honours the latency budget never sets this flag.

Top module: `xdom_word_fifo`

## Requirements
- R1: Four consecutive accepted bytes form one word, with the first byte in bits 7:0 and the fourth in bits 31:24. A word with fewer than four bytes is never written and cannot be seen on the read side.
- R2: Words leave the read port in exactly the order they were completed, with no loss or duplication while the store is not full.
- R3: `rd_en` while `rd_empty` is high has no effect. A word written afterwards is the next word presented.
- R4: After reset, `hold_off` and `overflow` are 0 and `rd_empty` is 1.
- R5: With THREE_Q = 3/4 of the depth (768 by default) and TRIP = depth/4 − LAT_WORDS (216 by default), `hold_off` rises at the clock edge that writes the TRIP-th word after the word that brought occupancy to THREE_Q. With no reads, that word is word 984.
- R6: Reads that leave occupancy at or above THREE_Q do not reset or reduce the count of R5.
- R7: Once high, `hold_off` stays high while the write-side occupancy is at least THREE_Q. It falls once that occupancy is below THREE_Q.
- R8: After a release, the count restarts from zero at the next crossing of THREE_Q.
- R9: From the edge where `hold_off` rises, exactly LAT_WORDS further words fill the store to 1024 entries without loss. A sender that checks `hold_off` only at the start of each 32-word cell never overflows the store.
- R10: A word completed while the store is full is discarded and sets `overflow`. `overflow` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_rst | input | 1 | Synchronous active-high reset, producer domain |
| in_byte | input | 8 | Incoming byte |
| in_valid | input | 1 | `in_byte` is valid this cycle |
| hold_off | output | 1 | Backpressure toward the sender |
| overflow | output | 1 | Sticky flag: a completed word was dropped |
| rd_clk | input | 1 | Consumer clock |
| rd_rst | input | 1 | Synchronous active-high reset, consumer domain |
| rd_en | input | 1 | Remove the presented word |
| rd_data | output | 32 | Oldest stored word (fall-through) |
| rd_empty | output | 1 | No word is available |

## Verification
Two things can happen on the same producer edge: the word that completes the trip count is written, and `hold_off` rises. They are provoked by streaming words with the consumer stalled, so the write-side occupancy is exact. A behavioural model then predicts `hold_off` and `overflow` on every producer clock. The second coincidence is that the trip count keeps running while reads drain words in the other domain. This is provoked by reading a few words after the crossing and checking that `hold_off` still rises by count, 8 words below the level-based point. A final concurrent phase streams cells against a slow consumer and judges the read order and the `overflow` flag.

// File: rtl/xdom_pkg.sv
`timescale 1ns/1ps
package xdom_pkg;

    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = BYTE_W * WORD_BYTES;
    localparam int LANE_W     = $clog2(WORD_BYTES);
    localparam int LOW_W      = WORD_W - BYTE_W;

    // backpressure controller states
    typedef enum logic [1:0] {
        BP_BELOW = 2'd0,
        BP_WATCH = 2'd1,
        BP_HOLD  = 2'd2
    } bp_state_e;

    // byte packer state: lane index and the bytes collected so far
    typedef struct packed {
        logic [LANE_W-1:0] lane;
        logic [LOW_W-1:0]  low;
    } pack_state_t;

    function automatic logic [LANE_W-1:0] lane_next(input logic [LANE_W-1:0] l);
        return l + LANE_W'(1);
    endfunction

endpackage

// File: rtl/xdom_packer.sv
`timescale 1ns/1ps
module xdom_packer
    import xdom_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_valid,
    output logic              word_push,
    output logic [WORD_W-1:0] word_data
);

    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(WORD_BYTES - 1);

    pack_state_t st;

    // last byte goes straight to the word port, no extra register stage
    assign word_push = in_valid && (st.lane == LAST_LANE);
    assign word_data = {in_byte, st.low};

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (in_valid) begin
            st.lane <= lane_next(st.lane);
            if (st.lane != LAST_LANE) begin
                st.low[int'(st.lane)*BYTE_W +: BYTE_W] <= in_byte;
            end
        end
    end

    // R1
    lane_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        word_push |=> (st.lane == '0));

endmodule

// File: rtl/xdom_gray_sync.sv
`timescale 1ns/1ps
module xdom_gray_sync #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);

    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= gray_in;
            stage2 <= stage1;
        end
    end

    // Gray to binary: each bit is the parity of itself and all higher bits
    for (genvar i = 0; i < W; i++) begin : g_conv
        assign bin_out[i] = ^stage2[W-1:i];
    end

endmodule

// File: rtl/xdom_async_core.sv
`timescale 1ns/1ps
module xdom_async_core #(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input  logic          wr_clk,
    input  logic          wr_rst,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    output logic [AW:0]   occ,
    output logic          accepted,
    output logic          overflow,
    input  logic          rd_clk,
    input  logic          rd_rst,
    input  logic          rd_en,
    output logic [DW-1:0] rdata,
    output logic          empty
);

    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    logic [PW-1:0] wr_bin, wr_gray, wr_bin_n, rsync_bin;
    logic [PW-1:0] rd_bin, rd_gray, rd_bin_n, wsync_bin;
    logic          full, wr_take, rd_take, ovf_q;

    // ---------------- write domain ----------------
    assign occ      = wr_bin - rsync_bin;
    assign full     = (occ == PW'(DEPTH));
    assign wr_take  = push && !full;
    assign accepted = wr_take;
    assign wr_bin_n = wr_bin + PW'(1);
    assign overflow = ovf_q;

    always_ff @(posedge wr_clk) begin
        if (wr_rst) begin
            wr_bin  <= '0;
            wr_gray <= '0;
            ovf_q   <= 1'b0;
        end else begin
            if (wr_take) begin
                wr_bin  <= wr_bin_n;
                wr_gray <= wr_bin_n ^ (wr_bin_n >> 1);
            end
            if (push && full) begin
                ovf_q <= 1'b1;
            end
        end
    end

    always_ff @(posedge wr_clk) begin
        if (wr_take) begin
            mem[wr_bin[AW-1:0]] <= wdata;
        end
    end

    xdom_gray_sync #(.W(PW)) u_rsync (
        .clk     (wr_clk),
        .rst     (wr_rst),
        .gray_in (rd_gray),
        .bin_out (rsync_bin)
    );

    // ---------------- read domain ----------------
    assign empty    = (rd_bin == wsync_bin);
    assign rd_take  = rd_en && !empty;
    assign rd_bin_n = rd_bin + PW'(1);
    assign rdata    = mem[rd_bin[AW-1:0]];

    always_ff @(posedge rd_clk) begin
        if (rd_rst) begin
            rd_bin  <= '0;
            rd_gray <= '0;
        end else if (rd_take) begin
            rd_bin  <= rd_bin_n;
            rd_gray <= rd_bin_n ^ (rd_bin_n >> 1);
        end
    end

    xdom_gray_sync #(.W(PW)) u_wsync (
        .clk     (rd_clk),
        .rst     (rd_rst),
        .gray_in (wr_gray),
        .bin_out (wsync_bin)
    );

    // R10
    ovf_sticky_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        overflow |=> overflow);

    // R10
    drop_full_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (push && full) |=> $stable(wr_bin));

    // R3
    pop_empty_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_en && empty) |=> $stable(rd_bin));

    // R2
    occ_bound_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        occ <= PW'(DEPTH));

endmodule

// File: rtl/xdom_bp_ctrl.sv
`timescale 1ns/1ps
module xdom_bp_ctrl
    import xdom_pkg::*;
#(
    parameter int AW        = 10,
    parameter int LAT_WORDS = 40
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        push,
    input  logic [AW:0] occ,
    output logic        hold_off
);

    localparam int DEPTH   = 1 << AW;
    localparam int THREE_Q = (DEPTH * 3) / 4;
    localparam int TRIP    = DEPTH / 4 - LAT_WORDS;
    localparam int CW      = $clog2(TRIP + 1);

    bp_state_e      st, st_n;
    logic [CW-1:0]  cnt, cnt_n;
    logic           above;

    assign above    = (occ >= (AW+1)'(THREE_Q));
    assign hold_off = (st == BP_HOLD);

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        unique case (st)
            BP_BELOW: begin
                if (above) begin
                    st_n  = BP_WATCH;
                    cnt_n = push ? CW'(1) : '0;
                end
            end
            BP_WATCH: begin
                if (!above) begin
                    st_n  = BP_BELOW;
                    cnt_n = '0;
                end else if (push) begin
                    cnt_n = cnt + CW'(1);
                end
            end
            BP_HOLD: begin
                if (!above) begin
                    st_n  = BP_BELOW;
                    cnt_n = '0;
                end
            end
            default: begin
                st_n  = BP_BELOW;
                cnt_n = '0;
            end
        endcase
        if (st_n == BP_WATCH && cnt_n == CW'(TRIP)) begin
            st_n = BP_HOLD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= BP_BELOW;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    // R7
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_off && above) |=> hold_off);

    // R5
    hold_on_push_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_off) |-> $past(push));

    // R8
    hold_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_off) |-> ($past(occ) >= (AW+1)'(THREE_Q)));

endmodule

// File: rtl/xdom_word_fifo.sv
`timescale 1ns/1ps
module xdom_word_fifo
    import xdom_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int LAT_WORDS = 40
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_valid,
    output logic              hold_off,
    output logic              overflow,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_empty
);

    logic              word_push;
    logic [WORD_W-1:0] word_data;
    logic [ADDR_W:0]   wr_occ;
    logic              word_taken;

    xdom_packer u_pack (
        .clk       (wr_clk),
        .rst       (wr_rst),
        .in_byte   (in_byte),
        .in_valid  (in_valid),
        .word_push (word_push),
        .word_data (word_data)
    );

    xdom_async_core #(.AW(ADDR_W), .DW(WORD_W)) u_core (
        .wr_clk   (wr_clk),
        .wr_rst   (wr_rst),
        .push     (word_push),
        .wdata    (word_data),
        .occ      (wr_occ),
        .accepted (word_taken),
        .overflow (overflow),
        .rd_clk   (rd_clk),
        .rd_rst   (rd_rst),
        .rd_en    (rd_en),
        .rdata    (rd_data),
        .empty    (rd_empty)
    );

    xdom_bp_ctrl #(.AW(ADDR_W), .LAT_WORDS(LAT_WORDS)) u_bp (
        .clk      (wr_clk),
        .rst      (wr_rst),
        .push     (word_taken),
        .occ      (wr_occ),
        .hold_off (hold_off)
    );

endmodule

// File: tb/sim_xdom_word_fifo.sv
`timescale 1ns/1ps
module sim_xdom_word_fifo;

    localparam int WR_PERIOD = 50;
    localparam int RD_PERIOD = 30;
    localparam int AW        = 10;
    localparam int LAT       = 40;
    localparam int DEPTH     = 1 << AW;
    localparam int THREE_Q   = DEPTH * 3 / 4;
    localparam int TRIP      = DEPTH / 4 - LAT;
    localparam int CELL      = 32;
    localparam int CELLS     = 60;
    localparam int WATCHDOG  = 150000;

    logic        wr_clk = 1'b0, rd_clk = 1'b0;
    logic        wr_rst = 1'b1, rd_rst = 1'b1;
    logic        in_valid = 1'b0, rd_en = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        hold_off, overflow, rd_empty;
    logic [31:0] rd_data;

    always #(WR_PERIOD/2) wr_clk = ~wr_clk;
    always #(RD_PERIOD/2) rd_clk = ~rd_clk;

    xdom_word_fifo #(.ADDR_W(AW), .LAT_WORDS(LAT)) u0 (
        .wr_clk   (wr_clk),
        .wr_rst   (wr_rst),
        .in_byte  (in_byte),
        .in_valid (in_valid),
        .hold_off (hold_off),
        .overflow (overflow),
        .rd_clk   (rd_clk),
        .rd_rst   (rd_rst),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .rd_empty (rd_empty)
    );

    int          checks = 0, fails = 0, wr_cycles = 0, word_idx = 0;
    logic [31:0] exp_q[$];
    int          m_occ = 0, m_since = 0;
    bit          m_armed = 0, m_hold = 0, m_ovf = 0, track = 0, saw_hold = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    // per-cycle comparison against the behavioural model
    always @(negedge wr_clk) begin
        wr_cycles++;
        if (!wr_rst) begin
            check("R10 overflow flag", {31'b0, overflow}, {31'b0, m_ovf});
            if (track) check("R5 hold_off per cycle", {31'b0, hold_off}, {31'b0, m_hold});
            if (hold_off) saw_hold = 1;
        end
        if (wr_cycles > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog (all requirements) actual=%0d expected<%0d", wr_cycles, WATCHDOG);
            summary();
        end
    end

    function automatic logic [31:0] next_word();
        word_idx++;
        return 32'(word_idx) * 32'h9E3779B1 + 32'h1;
    endfunction

    // model of one completed word
    task automatic model_word(input logic [31:0] w);
        if (m_occ >= DEPTH) begin
            m_ovf = 1;
        end else begin
            exp_q.push_back(w);
            if (m_armed) begin
                m_since++;
                if (m_since == TRIP) m_hold = 1;
            end
            m_occ++;
            if (!m_armed && m_occ >= THREE_Q) begin
                m_armed = 1;
                m_since = 0;
            end
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge wr_clk);
        in_byte  = b;
        in_valid = 1'b1;
        @(posedge wr_clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic send_word(input logic [31:0] w);
        for (int i = 0; i < 4; i++) send_byte(w[8*i +: 8]);
        model_word(w);
    endtask

    task automatic pop_words(input int n, input int gap);
        for (int k = 0; k < n; k++) begin
            @(negedge rd_clk);
            while (rd_empty) @(negedge rd_clk);
            check("R2 read order", rd_data, (exp_q.size() > 0) ? exp_q.pop_front() : 32'hDEADBEEF);
            rd_en = 1'b1;
            @(posedge rd_clk);
            #1;
            rd_en = 1'b0;
            m_occ--;
            repeat (gap) @(posedge rd_clk);
        end
    endtask

    task automatic settle();
        repeat (8) @(posedge wr_clk);
        repeat (8) @(posedge rd_clk);
        if (m_occ < THREE_Q) begin
            m_armed = 0;
            m_hold  = 0;
            m_since = 0;
        end
    endtask

    task automatic do_reset();
        track    = 0;
        in_valid = 1'b0;
        rd_en    = 1'b0;
        wr_rst   = 1'b1;
        rd_rst   = 1'b1;
        repeat (4) @(posedge wr_clk);
        repeat (4) @(posedge rd_clk);
        exp_q.delete();
        m_occ = 0; m_since = 0; m_armed = 0; m_hold = 0; m_ovf = 0;
        @(negedge wr_clk);
        wr_rst = 1'b0;
        @(negedge rd_clk);
        rd_rst = 1'b0;
    endtask

    initial begin
        do_reset();
        @(negedge wr_clk);
        check("R4 hold_off after reset", {31'b0, hold_off}, 32'd0);
        check("R4 overflow after reset", {31'b0, overflow}, 32'd0);
        check("R4 rd_empty after reset", {31'b0, rd_empty}, 32'd1);

        // R3: pops on an empty store are ignored
        @(negedge rd_clk);
        rd_en = 1'b1;
        repeat (6) @(negedge rd_clk);
        rd_en = 1'b0;
        check("R3 empty after pops on empty", {31'b0, rd_empty}, 32'd1);

        // R1: partial word invisible, byte order
        send_byte(8'hAA);
        send_byte(8'hBB);
        send_byte(8'hCC);
        repeat (12) @(negedge wr_clk);
        check("R1 partial word not visible", {31'b0, rd_empty}, 32'd1);
        send_byte(8'hDD);
        model_word(32'hDDCCBBAA);
        settle();
        @(negedge rd_clk);
        check("R3 word after empty pops present", {31'b0, rd_empty}, 32'd0);
        check("R1 byte order", rd_data, 32'hDDCCBBAA);
        pop_words(1, 0);
        settle();
        check("R3 empty again", {31'b0, rd_empty}, 32'd1);

        // R5 trip point with reads stalled, R9 exact fill, R10 drop
        track = 1;
        for (int i = 0; i < THREE_Q + TRIP - 1; i++) send_word(next_word());
        @(negedge wr_clk);
        check("R5 no hold one word before trip", {31'b0, hold_off}, 32'd0);
        send_word(next_word());
        @(negedge wr_clk);
        check("R5 hold at trip word", {31'b0, hold_off}, 32'd1);
        for (int i = 0; i < LAT; i++) send_word(next_word());
        @(negedge wr_clk);
        check("R9 latency budget fills without overflow", {31'b0, overflow}, 32'd0);
        send_word(32'hBADC0DE5);
        @(negedge wr_clk);
        check("R10 overflow set on full write", {31'b0, overflow}, 32'd1);
        track = 0;
        pop_words(DEPTH, 0);
        settle();
        check("R10 dropped word absent", {31'b0, rd_empty}, 32'd1);
        check("R10 overflow sticky", {31'b0, overflow}, 32'd1);
        check("R7 released after drain", {31'b0, hold_off}, 32'd0);

        // R6: count survives reads above three quarters
        do_reset();
        track = 1;
        for (int i = 0; i < THREE_Q + 10; i++) send_word(next_word());
        track = 0;
        pop_words(8, 0);
        settle();
        track = 1;
        check("R6 no hold after reads", {31'b0, hold_off}, 32'd0);
        for (int i = 0; i < TRIP - 11; i++) send_word(next_word());
        @(negedge wr_clk);
        check("R6 no hold before count", {31'b0, hold_off}, 32'd0);
        send_word(next_word());
        @(negedge wr_clk);
        check("R6 hold by count below level point", {31'b0, hold_off}, 32'd1);

        // R7 hysteresis
        track = 0;
        pop_words(200, 0);
        settle();
        track = 1;
        check("R7 hold kept above three quarters", {31'b0, hold_off}, 32'd1);
        track = 0;
        pop_words(9, 0);
        settle();
        track = 1;
        check("R7 hold released below three quarters", {31'b0, hold_off}, 32'd0);

        // R8 count restarts after release
        for (int i = 0; i < 11; i++) send_word(next_word());
        @(negedge wr_clk);
        check("R8 no hold just after recrossing", {31'b0, hold_off}, 32'd0);
        for (int i = 0; i < TRIP - 11; i++) send_word(next_word());
        @(negedge wr_clk);
        check("R8 no hold before restarted count", {31'b0, hold_off}, 32'd0);
        send_word(next_word());
        @(negedge wr_clk);
        check("R8 hold at restarted count", {31'b0, hold_off}, 32'd1);
        track = 0;
        pop_words(exp_q.size(), 0);
        settle();

        // R9 concurrent stress: sender checks hold only at cell starts
        do_reset();
        saw_hold = 0;
        fork
            begin
                for (int c = 0; c < CELLS; c++) begin
                    @(negedge wr_clk);
                    while (hold_off) @(negedge wr_clk);
                    for (int j = 0; j < CELL; j++) send_word(next_word());
                end
            end
            pop_words(CELLS * CELL, 19);
        join
        settle();
        check("R9 backpressure engaged", {31'b0, saw_hold}, 32'd1);
        check("R9 no overflow under stress", {31'b0, overflow}, 32'd0);
        check("R2 all words drained", {31'b0, rd_empty}, 32'd1);
        check("R2 model queue empty", 32'(exp_q.size()), 32'd0);

        summary();
    end

endmodule